// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block takes the two wires of a PS/2 port, as seen by the host, and recovers the bytes that the attached device clocks out. Both lines are only sampled and never driven. The device clock is debounced inside the block. A filtered clock level changes only when every sample in a fixed-length history agrees. Each falling edge of that filtered level produces a one-cycle tick, and the data line is read only on that tick.

A small state machine waits for a start bit, shifts in the data bits (least significant first) and the odd-parity bit, then takes the stop bit. After the stop bit it publishes the byte with a one-cycle completion pulse. A parity-error flag is published with the byte. A receive-enable input decides whether a new frame may begin. It is meant to be tied to the idle flag of a companion transmitter, so that host-to-device traffic takes priority. Once a frame has started, the enable no longer matters.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rx_done` is 0, `rx_byte` is 0x00 and `rx_perr` is 0.
- R2: A low level on `ps2_clk_in` registers as a falling edge only after it has been sampled low on 8 consecutive system clocks. A shorter low pulse starts no frame and produces no completion.
- R3: Once the filtered clock is low, a high pulse on `ps2_clk_in` shorter than 8 samples does not raise it. The low that follows therefore yields no second edge, and the bit count is not disturbed.
- R4: The data line is sampled only in the cycle of the falling-edge tick. The falling-edge tick fires in the cycle after the 8th consecutive low sample, and the data value at the following clock edge is taken. A change of `ps2_data_in` later in the same low phase has no effect on the received byte.
- R5: A frame is a start bit of 0, eight data bits sent least significant bit first, one parity bit and one stop bit. `rx_byte` bit i equals the i-th data bit received.
- R6: `rx_done` is 1 for exactly one system clock cycle per frame. That cycle begins at the clock edge at which the stop bit is sampled.
- R7: `rx_byte` changes only at the edge that raises `rx_done`. It holds its value in every other cycle.
- R8: A frame starts only when all three of these hold at the same clock edge: the falling-edge tick is present, `rx_en` is 1, and `ps2_data_in` is 0. A tick with the data line at 1, or with `rx_en` at 0, is ignored.
- R9: Deasserting `rx_en` after a frame has started does not abort it. The frame completes normally.
- R10: `rx_perr` is updated together with `rx_byte`. It is 1 when the eight data bits and the parity bit hold an even number of ones, and 0 otherwise.
- R11: The stop bit value is not checked. A frame whose stop bit reads 0 still completes with the correct byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| rx_en | input | 1 | Permits a new frame to begin (tie to transmitter idle) |
| ps2_clk_in | input | 1 | Raw PS/2 clock line as sampled by the host |
| ps2_data_in | input | 1 | Raw PS/2 data line as sampled by the host |
| rx_byte | output | 8 | Last received data byte |
| rx_done | output | 1 | One-cycle pulse when a frame has been received |
| rx_perr | output | 1 | Parity error flag for the byte on `rx_byte` |

## Verification
Two events can fall on the same clock edge: the start-bit falling tick, and a change of `rx_en` from the transmitter side. The bench moves `rx_en` in three ways around the start bit:
- It raises `rx_en` just before the sampling edge; the frame must be taken.
- It drops `rx_en` just before the sampling edge; the frame must be refused.
- It drops `rx_en` one cycle after the sampling edge; the frame must be taken.

A behavioural model predicts the outcome of each case from run-length counts of the clock line. The model is compared with `rx_done`, `rx_byte` and `rx_perr` on every cycle. Separate checks count completions and compare the final byte against constants.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_BITS = 2'd1,
      RX_LOAD = 2'd2
   } rx_state_e;

   function automatic int unsigned bits_for(input int unsigned value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/ps2rx_clk_filter.sv
module ps2rx_clk_filter #(
   parameter int unsigned HIST_LEN = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_clk,
   output logic filt_clk,
   output logic fall_tick
);

   if (HIST_LEN < 2) begin : g_bad_hist
      $error("ps2rx_clk_filter: HIST_LEN must be at least 2");
   end

   logic [HIST_LEN-1:0] hist_q;
   logic                level_q;
   logic                level_d;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hist_q  <= '0;
         level_q <= 1'b0;
      end else begin
         hist_q  <= {raw_clk, hist_q[HIST_LEN-1:1]};
         level_q <= level_d;
      end
   end

   always_comb begin
      level_d = level_q;
      if (&hist_q) begin
         level_d = 1'b1;
      end else if (~|hist_q) begin
         level_d = 1'b0;
      end
   end

   assign filt_clk  = level_q;
   assign fall_tick = level_q & ~level_d;

endmodule

// File: rtl/ps2rx_frame_fsm.sv
module ps2rx_frame_fsm
   import ps2rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_ok,
   input  logic              fall_tick,
   input  logic              data_bit,
   output logic              busy,
   output logic              done,
   output logic              load,
   output logic [DATA_W:0]   word_bits,
   output logic [DATA_W-1:0] byte_out
);

   localparam int unsigned PAY_W    = DATA_W + 1;
   localparam int unsigned CNT_INIT = PAY_W;
   localparam int unsigned CNT_W    = bits_for(CNT_INIT);

   rx_state_e          state_q, state_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic [PAY_W-1:0]   sreg_q, sreg_d;
   logic [DATA_W-1:0]  byte_q;
   logic               load_d;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         sreg_q  <= '0;
         byte_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         sreg_q  <= sreg_d;
         if (load_d) begin
            byte_q <= sreg_q[DATA_W-1:0];
         end
      end
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      sreg_d  = sreg_q;
      load_d  = 1'b0;
      unique case (state_q)
         RX_IDLE: begin
            if (start_ok && fall_tick && !data_bit) begin
               state_d = RX_BITS;
               cnt_d   = CNT_W'(CNT_INIT);
            end
         end
         RX_BITS: begin
            if (fall_tick) begin
               if (cnt_q == '0) begin
                  state_d = RX_LOAD;
                  load_d  = 1'b1;
               end else begin
                  sreg_d = {data_bit, sreg_q[PAY_W-1:1]};
                  cnt_d  = cnt_q - 1'b1;
               end
            end
         end
         RX_LOAD: begin
            state_d = RX_IDLE;
         end
         default: begin
            state_d = RX_IDLE;
         end
      endcase
   end

   assign busy      = (state_q != RX_IDLE);
   assign done      = (state_q == RX_LOAD);
   assign load      = load_d;
   assign word_bits = sreg_q;
   assign byte_out  = byte_q;

endmodule

// File: rtl/ps2rx_parity.sv
module ps2rx_parity #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          CHECK_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [DATA_W:0] word_bits,
   output logic            perr
);

   if (CHECK_EN) begin : g_check
      logic perr_q;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            perr_q <= 1'b0;
         end else if (load) begin
            perr_q <= ~(^word_bits);
         end
      end
      assign perr = perr_q;
   end else begin : g_nocheck
      logic unused_par;
      assign unused_par = ^{clk, rst, load, word_bits};
      assign perr       = 1'b0;
   end

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
   parameter int unsigned HIST_LEN  = 8,
   parameter int unsigned DATA_W    = 8,
   parameter bit          PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              ps2_clk_in,
   input  logic              ps2_data_in,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done,
   output logic              rx_perr
);

   if (DATA_W < 1) begin : g_bad_width
      $error("ps2_frame_rx: DATA_W must be at least 1");
   end

   logic            filt_clk;
   logic            fall_tick;
   logic            rx_busy;
   logic            word_load;
   logic [DATA_W:0] word_bits;
   logic            unused_filt;

   assign unused_filt = filt_clk;

   ps2rx_clk_filter #(
      .HIST_LEN (HIST_LEN)
   ) u_filter (
      .clk       (clk),
      .rst       (rst),
      .raw_clk   (ps2_clk_in),
      .filt_clk  (filt_clk),
      .fall_tick (fall_tick)
   );

   ps2rx_frame_fsm #(
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .start_ok  (rx_en),
      .fall_tick (fall_tick),
      .data_bit  (ps2_data_in),
      .busy      (rx_busy),
      .done      (rx_done),
      .load      (word_load),
      .word_bits (word_bits),
      .byte_out  (rx_byte)
   );

   ps2rx_parity #(
      .DATA_W   (DATA_W),
      .CHECK_EN (PARITY_EN)
   ) u_parity (
      .clk       (clk),
      .rst       (rst),
      .load      (word_load),
      .word_bits (word_bits),
      .perr      (rx_perr)
   );

endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk #(
   parameter int unsigned HIST_LEN = 8,
   parameter int unsigned DATA_W   = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_en,
   input logic              ps2_clk_in,
   input logic              ps2_data_in,
   input logic              fall_tick,
   input logic              busy,
   input logic              rx_done,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_perr
);

   localparam int unsigned RUN_W = ps2rx_pkg::bits_for(HIST_LEN);

   logic [RUN_W-1:0] low_run;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         low_run <= RUN_W'(HIST_LEN);
      end else if (ps2_clk_in) begin
         low_run <= '0;
      end else if (low_run != RUN_W'(HIST_LEN)) begin
         low_run <= low_run + 1'b1;
      end
   end

   assert_edge_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
      fall_tick |-> (low_run == RUN_W'(HIST_LEN)));

   assert_done_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_done) |-> $past(fall_tick));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
      rx_done |=> !rx_done);

   assert_byte_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !rx_done |-> $stable(rx_byte));

   assert_start_gate_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(rx_en && fall_tick && !ps2_data_in));

   assert_perr_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !rx_done |-> $stable(rx_perr));

endmodule

bind ps2_frame_rx ps2_frame_rx_chk #(
   .HIST_LEN (HIST_LEN),
   .DATA_W   (DATA_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .rx_en       (rx_en),
   .ps2_clk_in  (ps2_clk_in),
   .ps2_data_in (ps2_data_in),
   .fall_tick   (fall_tick),
   .busy        (rx_busy),
   .rx_done     (rx_done),
   .rx_byte     (rx_byte),
   .rx_perr     (rx_perr)
);

// File: tb/tb_ps2_frame_rx.sv
module tb_ps2_frame_rx;

   localparam int HALF = 20;
   localparam int RUN  = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b1;
   logic       ps2c = 1'b1;
   logic       ps2d = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_done;
   logic       rx_perr;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int done_cnt = 0;

   always #10 clk = ~clk;

   ps2_frame_rx dut (
      .clk         (clk),
      .rst         (rst),
      .rx_en       (en),
      .ps2_clk_in  (ps2c),
      .ps2_data_in (ps2d),
      .rx_byte     (rx_byte),
      .rx_done     (rx_done),
      .rx_perr     (rx_perr)
   );

   // behavioural reference: run lengths of the clock line and a bit queue
   int         m_low = RUN;
   int         m_high = 0;
   bit         m_filt = 1'b0;
   bit         m_active = 1'b0;
   bit         m_done = 1'b0;
   bit         m_perr = 1'b0;
   bit [7:0]   m_byte = 8'h00;
   bit         m_bits[$];

   always @(posedge clk or posedge rst) begin : model
      bit nf;
      bit tick;
      bit was_done;
      if (rst) begin
         m_low = RUN; m_high = 0; m_filt = 1'b0; m_active = 1'b0;
         m_done = 1'b0; m_perr = 1'b0; m_byte = 8'h00; m_bits.delete();
      end else begin
         nf = m_filt;
         if (m_high >= RUN) nf = 1'b1;
         else if (m_low >= RUN) nf = 1'b0;
         tick = m_filt && !nf;
         m_filt = nf;
         if (ps2c) begin m_high++; m_low = 0; end
         else begin m_low++; m_high = 0; end
         was_done = m_done;
         m_done = 1'b0;
         if (m_active) begin
            if (tick) begin
               m_bits.push_back(ps2d);
               if (m_bits.size() == 10) begin
                  for (int i = 0; i < 8; i++) m_byte[i] = m_bits[i];
                  m_perr = (((^m_byte) ^ m_bits[8]) == 1'b0);
                  m_done = 1'b1;
                  m_active = 1'b0;
               end
            end
         end else if (!was_done && tick && en && !ps2d) begin
            m_active = 1'b1;
            m_bits.delete();
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("R6 rx_done vs model", int'(rx_done), int'(m_done));
         chk("R7 rx_byte vs model", int'(rx_byte), int'(m_byte));
         chk("R10 rx_perr vs model", int'(rx_perr), int'(m_perr));
         if (rx_done) done_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog R5 actual=%0d expected=<150000 cycles", cyc);
         report();
         $finish;
      end
   end

   // en_mode: 0 none, 1 raise at start edge, 2 drop at start edge,
   //          3 drop one cycle after start edge, 4 drop mid-frame
   task automatic send_frame(input logic [7:0] d, input bit par_flip,
                             input bit stop_v, input int en_mode,
                             input bit late_flip, input bit hi_glitch);
      logic [10:0] fb;
      fb = {stop_v, (~^d) ^ par_flip, d, 1'b0};
      for (int k = 0; k < 11; k++) begin
         @(negedge clk);
         ps2c = 1'b1;
         ps2d = fb[k];
         if (en_mode == 4 && k == 3) en = 1'b0;
         repeat (HALF - 1) @(negedge clk);
         for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            if (i == 0) ps2c = 1'b0;
            if (k == 0 && i == 8) begin
               if (en_mode == 1) en = 1'b1;
               if (en_mode == 2) en = 1'b0;
            end
            if (k == 0 && i == 9 && en_mode == 3) en = 1'b0;
            if (late_flip && i == 12) ps2d = ~fb[k];
            if (hi_glitch && k == 2) begin
               if (i == 12) ps2c = 1'b1;
               if (i == 16) ps2c = 1'b0;
            end
         end
      end
      @(negedge clk);
      ps2c = 1'b1;
      ps2d = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic low_pulse(input int n, input bit dval);
      @(negedge clk);
      ps2d = dval;
      ps2c = 1'b0;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      ps2c = 1'b1;
      ps2d = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rx_done in reset", int'(rx_done), 0);
      chk("R1 rx_byte in reset", int'(rx_byte), 0);
      chk("R1 rx_perr in reset", int'(rx_perr), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 rx_done after release", int'(rx_done), 0);
      chk("R1 rx_byte after release", int'(rx_byte), 0);
      repeat (20) @(negedge clk);

      // R5 plain frame, good parity
      send_frame(8'hA5, 1'b0, 1'b1, 0, 1'b0, 1'b0);
      chk("R6 one completion for A5", done_cnt, 1);
      chk("R5 byte A5", int'(rx_byte), 8'hA5);
      chk("R10 no parity error for A5", int'(rx_perr), 0);

      // R10 corrupted parity
      send_frame(8'h3C, 1'b1, 1'b1, 0, 1'b0, 1'b0);
      chk("R5 byte 3C", int'(rx_byte), 8'h3C);
      chk("R10 parity error for 3C", int'(rx_perr), 1);

      // R2 short low pulse with data low
      low_pulse(5, 1'b0);
      low_pulse(RUN - 1, 1'b0);
      chk("R2 short lows start nothing", done_cnt, 2);

      // R8 full-length edge with data high in idle
      low_pulse(HALF, 1'b1);
      chk("R8 tick with data high ignored", done_cnt, 2);

      // R3 high glitch inside a low phase
      send_frame(8'h5A, 1'b0, 1'b1, 0, 1'b0, 1'b1);
      chk("R3 glitched frame completes once", done_cnt, 3);
      chk("R3 glitched frame byte", int'(rx_byte), 8'h5A);
      chk("R10 perr cleared for 5A", int'(rx_perr), 0);

      // R4 data changes after the sampling tick
      send_frame(8'hC3, 1'b0, 1'b1, 0, 1'b1, 1'b0);
      chk("R4 late data change ignored", int'(rx_byte), 8'hC3);

      // R8 enable raised on the start-bit sampling edge
      en = 1'b0;
      send_frame(8'h11, 1'b0, 1'b1, 1, 1'b0, 1'b0);
      chk("R8 enable raised at start edge accepted", done_cnt, 5);
      chk("R8 byte 11", int'(rx_byte), 8'h11);

      // R8 enable dropped on the start-bit sampling edge
      send_frame(8'h22, 1'b0, 1'b1, 2, 1'b0, 1'b0);
      chk("R8 enable dropped at start edge refused", done_cnt, 5);
      chk("R8 byte unchanged after refusal", int'(rx_byte), 8'h11);
      en = 1'b1;
      repeat (10) @(negedge clk);

      // R9 enable dropped one cycle after the start edge
      send_frame(8'h44, 1'b0, 1'b1, 3, 1'b0, 1'b0);
      chk("R9 drop after start edge completes", done_cnt, 6);
      chk("R9 byte 44", int'(rx_byte), 8'h44);
      en = 1'b1;
      repeat (10) @(negedge clk);

      // R9 enable dropped mid-frame
      send_frame(8'h99, 1'b0, 1'b1, 4, 1'b0, 1'b0);
      chk("R9 mid-frame drop completes", done_cnt, 7);
      chk("R9 byte 99", int'(rx_byte), 8'h99);
      en = 1'b1;
      repeat (10) @(negedge clk);

      // R11 stop bit low
      send_frame(8'h7E, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      chk("R11 frame with low stop completes", done_cnt, 8);
      chk("R11 byte 7E", int'(rx_byte), 8'h7E);

      report();
      $finish;
   end

endmodule